// File: doc/BRIEF.md
# Fast-off timer with SMI gating and stop-clock control

This block is a power-management controller. It watches activity, counts an idle interval, and raises a system-management interrupt. Each activity pulse reloads a down-counter from a programmable value. A selectable prescaler steps the counter, and when the count runs out the block records a timer-expired event. Activity pulses and timer expiry both set one pending flag. That flag drives the active-low SMI line, but only while a gate bit in the control register is set. The flag is recorded whatever the gate is doing, so a pending event shows up on the SMI line as soon as the gate opens. A dedicated acknowledge input clears the flag.

The same control register arms a stop-clock request. When the request is armed, a read of the power-management command port drives the active-low stop-clock line low. Any write to that port drops the line and disarms the request. The register also holds a clock-scale enable bit, which is only stored here. All logic runs on the PCI-rate clock. The tick lengths are parameters, so simulation can use short intervals.

Top module: `pm_fastoff_ctrl`

## Requirements
- R1: After reset `smi_no` and `stpclk_no` are 1, `ctl_rdata_o` is 0x00 and `fo_expired_o` is 0.
- R2: Control register layout: bit 0 is the SMI gate, bit 1 arms the stop-clock request, bit 2 is the clock-scale enable, bits 4:3 select the tick mode, and bits 7:5 always read 0. A write with `ctl_we_i` is visible on `ctl_rdata_o` after the clock edge.
- R3: An `evt_i` pulse sets the pending flag. `smi_no` is 0 exactly while the flag is set and the gate bit is 1.
- R4: The pending flag is kept while the gate is 0. Setting the gate drives `smi_no` low in the cycle after the write.
- R5: `smi_ack_i` clears the pending flag, and `smi_no` returns to 1 in the cycle after the acknowledge. If an event or an expiry arrives in the same cycle as the acknowledge, the flag stays set.
- R6: Tick mode 2'b10 ticks on every clock. An event loads the counter with `fo_reload_i`, and `fo_expired_o` pulses for one cycle exactly `fo_reload_i` edges after the loading edge. The expiry also sets the pending flag.
- R7: Tick mode 2'b11 ticks once every MS_CYCLES clocks and mode 2'b00 ticks once every MIN_CYCLES clocks. In these modes expiry comes `fo_reload_i` × period edges after the loading edge.
- R8: Tick mode 2'b01 freezes the counter and produces no expiry. Leaving that mode resumes the count from the value it was holding.
- R9: An event that arrives while the counter is running restarts the full interval.
- R10: A port read (`apm_rd_i`) while bit 1 is set drives `stpclk_no` low. While bit 1 is 0 a port read leaves `stpclk_no` at 1.
- R11: A port write (`apm_wr_i`) drives `stpclk_no` high and clears bit 1. A register write with bit 1 at 0 also releases `stpclk_no`.
- R12: After reset the counter is idle and nothing expires until the first event loads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PCI-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Activity/SMI event pulses |
| apm_wr_i | input | 1 | Write strobe for the power-management command port |
| apm_rd_i | input | 1 | Read strobe for the power-management command port |
| ctl_we_i | input | 1 | Control register write enable |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read data |
| fo_reload_i | input | CNT_W | Fast-off reload value |
| smi_ack_i | input | 1 | Clears the pending flag |
| smi_no | output | 1 | SMI request, active low |
| stpclk_no | output | 1 | Stop-clock request, active low |
| fo_expired_o | output | 1 | One-cycle pulse on fast-off expiry |

## Verification
The assertions assume that every input is synchronous to `clk_i` and that each strobe is sampled only once per edge. On that basis they treat a strobe that is high at an edge as one port access and a high event bit as one activity pulse. They do not assume that the port strobes, the acknowledge and the events are mutually exclusive, so the bench overlaps an acknowledge with an event on purpose. The bench changes every input one nanosecond after a rising edge, which keeps it inside those assumptions. It holds `fo_reload_i` steady across each counted interval, because the expected expiry edge is computed from the value that was loaded.

// File: rtl/pm_fastoff_pkg.sv
package pm_fastoff_pkg;
  typedef enum logic [1:0] {
    TM_MINUTE = 2'b00,
    TM_FROZEN = 2'b01,
    TM_CLOCK  = 2'b10,
    TM_MILLI  = 2'b11
  } tick_mode_e;

  typedef struct packed {
    logic [2:0] rsvd;
    tick_mode_e mode;
    logic       scale_en;
    logic       stp_en;
    logic       smi_gate;
  } ctl_t;
endpackage

// File: rtl/pm_tick_gen.sv
module pm_tick_gen
  import pm_fastoff_pkg::*;
#(
  parameter int MS_CYCLES  = 33_000,
  parameter int MIN_CYCLES = 1_980_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  tick_mode_e mode_i,
  input  logic       restart_i,
  output logic       tick_o
);
  localparam int MAXC = (MIN_CYCLES > MS_CYCLES) ? MIN_CYCLES : MS_CYCLES;
  localparam int PW   = $clog2(MAXC) + 1;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] lim;
  logic          scaled;

  always_comb begin
    lim    = (mode_i == TM_MILLI) ? PW'(MS_CYCLES - 1) : PW'(MIN_CYCLES - 1);
    scaled = (mode_i == TM_MILLI) || (mode_i == TM_MINUTE);
    tick_o = (mode_i == TM_CLOCK) || (scaled && (pcnt_q == lim));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pcnt_q <= '0;
    else if (restart_i)     pcnt_q <= '0;
    else if (scaled) begin
      if (pcnt_q == lim)    pcnt_q <= '0;
      else                  pcnt_q <= pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pm_fastoff_cnt.sv
module pm_fastoff_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             hit_o,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             exp_q;

  // reload beats expiry in the same cycle
  assign hit_o     = !load_i && run_q && tick_i && (cnt_q <= CNT_W'(1));
  assign expired_o = exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= hit_o;
      if (load_i) begin
        cnt_q <= load_val_i;
        run_q <= 1'b1;
      end else if (hit_o) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else if (run_q && tick_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pm_fastoff_ctrl.sv
module pm_fastoff_ctrl
  import pm_fastoff_pkg::*;
#(
  parameter int NUM_EVT    = 4,
  parameter int CNT_W      = 16,
  parameter int MS_CYCLES  = 33_000,
  parameter int MIN_CYCLES = 1_980_000_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               apm_wr_i,
  input  logic               apm_rd_i,
  input  logic               ctl_we_i,
  input  logic [7:0]         ctl_wdata_i,
  output logic [7:0]         ctl_rdata_o,
  input  logic [CNT_W-1:0]   fo_reload_i,
  input  logic               smi_ack_i,
  output logic               smi_no,
  output logic               stpclk_no,
  output logic               fo_expired_o
);
  ctl_t ctl_q, ctl_n, ctl_w;
  logic pend_q, stp_q;
  logic any_evt, tick, hit, restart;

  assign any_evt = |evt_i;
  assign ctl_w   = ctl_t'({3'b000, ctl_wdata_i[4:0]});
  assign restart = any_evt || (ctl_we_i && (ctl_w.mode != ctl_q.mode));

  always_comb begin
    ctl_n = ctl_q;
    if (ctl_we_i) ctl_n = ctl_w;
    if (apm_wr_i) ctl_n.stp_en = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      pend_q <= 1'b0;
      stp_q  <= 1'b0;
    end else begin
      ctl_q <= ctl_n;
      if (any_evt || hit)  pend_q <= 1'b1;
      else if (smi_ack_i)  pend_q <= 1'b0;
      if (apm_wr_i || (ctl_we_i && !ctl_w.stp_en)) stp_q <= 1'b0;
      else if (apm_rd_i && ctl_q.stp_en)          stp_q <= 1'b1;
    end
  end

  pm_tick_gen #(
    .MS_CYCLES (MS_CYCLES),
    .MIN_CYCLES(MIN_CYCLES)
  ) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (ctl_q.mode),
    .restart_i(restart),
    .tick_o   (tick)
  );

  pm_fastoff_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (any_evt),
    .load_val_i(fo_reload_i),
    .tick_i    (tick),
    .hit_o     (hit),
    .expired_o (fo_expired_o)
  );

  assign ctl_rdata_o = ctl_q;
  assign smi_no      = !(pend_q && ctl_q.smi_gate);
  assign stpclk_no   = !stp_q;
endmodule

// File: rtl/pm_fastoff_ctrl_chk.sv
module pm_fastoff_ctrl_chk #(
  parameter int NUM_EVT = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               apm_wr_i,
  input logic               apm_rd_i,
  input logic               smi_ack_i,
  input logic [7:0]         ctl_rdata_o,
  input logic               smi_no,
  input logic               stpclk_no,
  input logic               fo_expired_o
);
  p_gate_blocks_smi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smi_no |-> ctl_rdata_o[0]);

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[7:5] == 3'b000);

  p_ack_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smi_ack_i && (evt_i == '0)) |=> (smi_no || fo_expired_o));

  p_expiry_pends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fo_expired_o && ctl_rdata_o[0]) |-> !smi_no);

  p_frozen_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[4:3] == 2'b01) |=> !fo_expired_o);

  p_stp_needs_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stpclk_no) |-> ($past(apm_rd_i) && $past(ctl_rdata_o[1])));

  p_port_write_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apm_wr_i |=> (stpclk_no && !ctl_rdata_o[1]));

  p_expired_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fo_expired_o |=> !fo_expired_o);
endmodule

bind pm_fastoff_ctrl pm_fastoff_ctrl_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_i),
  .apm_wr_i    (apm_wr_i),
  .apm_rd_i    (apm_rd_i),
  .smi_ack_i   (smi_ack_i),
  .ctl_rdata_o (ctl_rdata_o),
  .smi_no      (smi_no),
  .stpclk_no   (stpclk_no),
  .fo_expired_o(fo_expired_o)
);

// File: tb/pm_fastoff_ctrl_tb_top.sv
`timescale 1ns/1ps
module pm_fastoff_ctrl_tb_top;
  localparam int NE = 4;
  localparam int CW = 16;
  localparam int MS = 4;
  localparam int MN = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic          apm_wr = 1'b0, apm_rd = 1'b0, ctl_we = 1'b0, ack = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [CW-1:0] reload = '0;
  logic          smi_n, stp_n, expd;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  pm_fastoff_ctrl #(.NUM_EVT(NE), .CNT_W(CW), .MS_CYCLES(MS), .MIN_CYCLES(MN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .apm_wr_i(apm_wr), .apm_rd_i(apm_rd),
    .ctl_we_i(ctl_we), .ctl_wdata_i(wdata), .ctl_rdata_o(rdata), .fo_reload_i(reload),
    .smi_ack_i(ack), .smi_no(smi_n), .stpclk_no(stp_n), .fo_expired_o(expd));

  // {write data, expected readback}
  localparam logic [15:0] REG_VEC [6] = '{
    16'hFF_1F, 16'h15_15, 16'hE0_00, 16'h0A_0A, 16'h13_13, 16'h00_00};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_we = 1'b1; wdata = d; step(); ctl_we = 1'b0;
  endtask

  task automatic fire(input logic [NE-1:0] e);
    evt = e; step(); evt = '0;
  endtask

  task automatic wait_exp(output int n);
    n = 0;
    while (!expd && n < 1000) begin step(); n++; end
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int n;
    bit seen;
    repeat (3) @(posedge clk);
    #1;
    chk(smi_n && stp_n && rdata == 8'h00 && !expd, "R1 reset state", {smi_n, stp_n, expd}, 6);
    rst_n = 1'b1;
    step();

    // R12: idle until first event
    reload = 16'd3; wr_ctl(8'h10);
    seen = 0;
    for (int i = 0; i < 40; i++) begin step(); if (expd) seen = 1; end
    chk(!seen, "R12 no expiry before load", seen, 0);

    // R2: register table
    for (int i = 0; i < 6; i++) begin
      wr_ctl(REG_VEC[i][15:8]);
      chk(rdata == REG_VEC[i][7:0], "R2 register readback", rdata, REG_VEC[i][7:0]);
    end

    // R3/R4: gated event then open gate
    wr_ctl(8'h08);                       // frozen, gate off
    fire(4'b0100);
    chk(smi_n, "R3 gate off keeps smi high", smi_n, 1);
    step(); step();
    chk(smi_n, "R4 still high while gated", smi_n, 1);
    wr_ctl(8'h09);
    chk(!smi_n, "R4 smi low after gate set", smi_n, 0);

    // R5: ack, and ack with simultaneous event
    do_ack();
    chk(smi_n, "R5 smi high after ack", smi_n, 1);
    fire(4'b0001);
    chk(!smi_n, "R3 event asserts smi", smi_n, 0);
    evt = 4'b0010; ack = 1'b1; step(); evt = '0; ack = 1'b0;
    chk(!smi_n, "R5 event beats ack", smi_n, 0);
    do_ack();

    // R6: clock mode, expiry after reload edges
    wr_ctl(8'h11);
    reload = 16'd5; fire(4'b0001); do_ack();
    n = 1; wait_exp(n); n = n + 1;
    chk(n == 5, "R6 clock-mode interval", n, 5);
    chk(!smi_n, "R6 expiry sets pending", smi_n, 0);
    step();
    chk(!expd, "R6 expiry is one cycle", expd, 0);
    do_ack();

    // R7: millisecond and minute modes
    wr_ctl(8'h19); reload = 16'd3; fire(4'b1000);
    wait_exp(n);
    chk(n == 3 * MS, "R7 millisecond interval", n, 3 * MS);
    wr_ctl(8'h01); reload = 16'd2; fire(4'b1000);
    wait_exp(n);
    chk(n == 2 * MN, "R7 minute interval", n, 2 * MN);
    do_ack();

    // R8: freeze and resume
    wr_ctl(8'h11); reload = 16'd6; fire(4'b0001);
    step(); step();
    wr_ctl(8'h09);                       // cnt 3 left
    seen = 0;
    for (int i = 0; i < 20; i++) begin step(); if (expd) seen = 1; end
    chk(!seen, "R8 frozen no expiry", seen, 0);
    wr_ctl(8'h11);
    wait_exp(n);
    chk(n == 3, "R8 resume remaining", n, 3);
    do_ack();

    // R9: restart while running
    reload = 16'd8; fire(4'b0001);
    repeat (5) step();
    fire(4'b0010);
    wait_exp(n);
    chk(n == 8, "R9 restart full interval", n, 8);
    do_ack();

    // R10/R11: stop-clock
    wr_ctl(8'h00);
    apm_rd = 1'b1; step(); apm_rd = 1'b0;
    chk(stp_n, "R10 read ignored when disarmed", stp_n, 1);
    wr_ctl(8'h02);
    apm_rd = 1'b1; step(); apm_rd = 1'b0;
    chk(!stp_n, "R10 read asserts stop-clock", stp_n, 0);
    apm_wr = 1'b1; step(); apm_wr = 1'b0;
    chk(stp_n && rdata[1] == 1'b0, "R11 port write releases", {stp_n, rdata[1]}, 2);
    wr_ctl(8'h02);
    apm_rd = 1'b1; step(); apm_rd = 1'b0;
    wr_ctl(8'h00);
    chk(stp_n, "R11 register clear releases", stp_n, 1);

    done = 1'b1;
    summary();
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end
endmodule